// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block is the interrupt logic of one bank of general-purpose I/O lines (32 by default). Each line carries its own 3-bit event-select field. The field picks one of five trigger kinds: a rising edge, a falling edge, either edge, a low level or a high level. Events are caught in a pending register whatever the mask holds. That register is sticky and is emptied by the act of reading it.

An interrupt mask gates the pending bits onto a single interrupt output for the whole bank. Software never writes the mask directly. Writing ones at an arm offset sets mask bits, and writing ones at a disarm offset clears them. The mask itself can be read back at its own offset.

The pin levels arrive already synchronised to the block clock. The register bus is a simple strobed interface with an address, a read strobe, a write strobe and 32-bit data. The block releases its asynchronous reset synchronously through an internal two-flop stage.

Top module: `gpio_irq_events`

## Requirements
- R1: Select codes 0, 1 and 2 mean falling edge, rising edge and either edge. An edge is found by comparing the present pin sample with the sample held from the previous clock, and a found edge sets that line's pending bit.
- R2: Select codes 3 and 4 mean low level and high level. The pending bit is set on every clock where the level is present, so a read empties the bit only when the level has already gone.
- R3: Select codes 5, 6 and 7 are reserved, and a line set to any of them never sets its pending bit.
- R4: A pending bit stays set until the pending register is read at offset 0x2C. That read returns the pending bits and clears them.
- R5: An event detected in the same clock as a pending-register read is still set after the read, and shows up in the next read.
- R6: A write at offset 0x20 sets every mask bit written as 1. A write at offset 0x24 clears every mask bit written as 1. Bits written as 0 leave the mask unchanged. The mask reads back at offset 0x28.
- R7: The interrupt output is high exactly when some bit is set in both the pending register and the mask. Pending bits latch whether or not their line is masked.
- R8: After reset the mask, the pending register and every line's held previous sample are 0, and the interrupt output is low.
- R9: Reading the mask and writing the arm or disarm offsets leave the pending register unchanged. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_LINES | Synchronised pin levels, one per line |
| evt_sel | input | 3*NUM_LINES | Per-line event-select field, line i at bits [3i+2:3i] |
| bus_addr | input | ADDR_W | Register offset within the bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Bank interrupt request |

## Verification
The case that needs care is a pending-register read landing in the same clock as a fresh detection, because clearing and setting then compete for the same bit. The bench provokes this in two ways: it drives an edge in the cycle of a read, and it holds an active level across several reads. It judges each read by two things: the read must return only the events seen before that clock, and the next read must show the event that arrived during the clear. A sweep over pseudo-random pin patterns, with all eight select codes spread across the lines, compares every read and the interrupt output with a model built from the requirements.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_mode_e;

  localparam int SEL_W = 3;

  localparam logic [7:0] OFS_ARM    = 8'h20;
  localparam logic [7:0] OFS_DISARM = 8'h24;
  localparam logic [7:0] OFS_MASKV  = 8'h28;
  localparam logic [7:0] OFS_PEND   = 8'h2C;
endpackage

// File: rtl/evt_rst_sync.sv
`timescale 1ns/1ps
module evt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/evt_line_detect.sv
`timescale 1ns/1ps
module evt_line_detect
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  logic prev_q;
  logic prev_d;
  logic hit;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    case (sel_i)
      EV_FALL: hit = prev_q & ~lvl_i;
      EV_RISE: hit = ~prev_q & lvl_i;
      EV_BOTH: hit = prev_q ^ lvl_i;
      EV_LOW:  hit = ~lvl_i;
      EV_HIGH: hit = lvl_i;
      default: hit = 1'b0;
    endcase
  end

  assign hit_o = hit;

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i > 3'd4) |-> !hit_o); // R3

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i <= 3'd2) && hit_o) |=> ($past(lvl_i) != $past(prev_q))); // R1

  AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd4) |-> (hit_o == lvl_i)); // R2
endmodule

// File: rtl/evt_mask_reg.sv
`timescale 1ns/1ps
module evt_mask_reg #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mask_o
);
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_d;
  logic                 mask_en;

  always_comb begin
    mask_en = set_i | clr_i;
    mask_d  = mask_q;
    if (set_i) mask_d = mask_q | wdata_i;
    if (clr_i) mask_d = mask_d & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R6

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((mask_o & $past(wdata_i)) == '0)); // R6

  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i || clr_i) |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i)))); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(mask_o)); // R6
endmodule

// File: rtl/evt_pend_reg.sv
`timescale 1ns/1ps
module evt_pend_reg #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hit_i,
  input  logic                 rd_clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] kept;

  always_comb begin
    kept   = rd_clr_i ? '0 : pend_q;
    pend_d = kept | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R4

  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (pend_o == $past(hit_i))); // R5
endmodule

// File: rtl/evt_bus_decode.sv
`timescale 1ns/1ps
module evt_bus_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              arm_o,
  output logic              disarm_o,
  output logic              mask_rd_o,
  output logic              pend_rd_o
);
  always_comb begin
    arm_o     = wr_i && (addr_i == ADDR_W'(OFS_ARM));
    disarm_o  = wr_i && (addr_i == ADDR_W'(OFS_DISARM));
    mask_rd_o = rd_i && (addr_i == ADDR_W'(OFS_MASKV));
    pend_rd_o = rd_i && (addr_i == ADDR_W'(OFS_PEND));
  end
endmodule

// File: rtl/gpio_irq_events.sv
`timescale 1ns/1ps
module gpio_irq_events
  import evt_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic [NUM_LINES-1:0]       pin_lvl,
  input  logic [NUM_LINES*SEL_W-1:0] evt_sel,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [NUM_LINES-1:0]       bus_wdata,
  output logic [NUM_LINES-1:0]       bus_rdata,
  output logic                       irq
);
  logic                 rst_n;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] mask;
  logic                 arm_stb;
  logic                 disarm_stb;
  logic                 mask_rd;
  logic                 pend_rd;

  evt_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    evt_line_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (pin_lvl[i]),
      .sel_i (evt_sel[i*SEL_W +: SEL_W]),
      .hit_o (hit[i])
    );
  end

  evt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .arm_o     (arm_stb),
    .disarm_o  (disarm_stb),
    .mask_rd_o (mask_rd),
    .pend_rd_o (pend_rd)
  );

  evt_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (arm_stb),
    .clr_i   (disarm_stb),
    .wdata_i (bus_wdata),
    .mask_o  (mask)
  );

  evt_pend_reg #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .rd_clr_i (pend_rd),
    .pend_o   (pend)
  );

  always_comb begin
    bus_rdata = '0;
    if (pend_rd)      bus_rdata = pend;
    else if (mask_rd) bus_rdata = mask;
  end

  assign irq = |(pend & mask);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_stb, disarm_stb, mask_rd, pend_rd})); // R9

  AST_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R7

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq && (pend == '0) && (mask == '0))); // R8
endmodule

// File: tb/sim_gpio_irq_events.sv
`timescale 1ns/1ps
module sim_gpio_irq_events;
  localparam int N = 32;
  localparam logic [7:0] A_ARM = 8'h20, A_DIS = 8'h24, A_MSK = 8'h28, A_PND = 8'h2C;

  logic           clk = 1'b0;
  logic           arst_n;
  logic [N-1:0]   pin_lvl;
  logic [N*3-1:0] evt_sel;
  logic [7:0]     bus_addr;
  logic           bus_wr, bus_rd;
  logic [N-1:0]   bus_wdata;
  logic [N-1:0]   bus_rdata;
  logic           irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0]   sel_b [N];
  logic [N-1:0] exp_stat = '0, exp_mask = '0, exp_prev = '0;
  logic [31:0]  lfsr = 32'h1D2C_3B4A;

  always #2 clk = ~clk;

  gpio_irq_events u0 (
    .clk(clk), .arst_n(arst_n), .pin_lvl(pin_lvl), .evt_sel(evt_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] hit_of(input logic [N-1:0] p);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      case (sel_b[i])
        3'd0:    h[i] = exp_prev[i] & ~p[i];
        3'd1:    h[i] = ~exp_prev[i] & p[i];
        3'd2:    h[i] = exp_prev[i] ^ p[i];
        3'd3:    h[i] = ~p[i];
        3'd4:    h[i] = p[i];
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  // one clock: drive at negedge, check read data, then irq after the edge
  task automatic cyc(input logic [N-1:0] pins, input bit rd, input bit wr,
                     input logic [7:0] addr, input logic [N-1:0] wd, input string tag);
    logic [N-1:0] nh, er;
    for (int i = 0; i < N; i++) evt_sel[i*3 +: 3] = sel_b[i];
    pin_lvl = pins; bus_addr = addr; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    #0.5;
    if (rd) begin
      er = (addr == A_PND) ? exp_stat : (addr == A_MSK) ? exp_mask : '0;
      chk(bus_rdata, er, tag);
    end
    nh = hit_of(pins);
    @(negedge clk);
    exp_stat = ((rd && addr == A_PND) ? '0 : exp_stat) | nh;
    if (wr && addr == A_ARM) exp_mask = exp_mask | wd;
    if (wr && addr == A_DIS) exp_mask = exp_mask & ~wd;
    exp_prev = pins;
    bus_rd = 0; bus_wr = 0;
    #0.5;
    chk({{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(exp_stat & exp_mask)}, {tag, " irq R7"});
  endtask

  task automatic set_all(input logic [2:0] s);
    for (int i = 0; i < N; i++) sel_b[i] = s;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_all(3'd0);
    for (int i = 0; i < N; i++) evt_sel[i*3 +: 3] = 3'd0;
    arst_n = 0; pin_lvl = '0; bus_addr = A_PND; bus_rd = 1; bus_wr = 0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    #0.5;
    chk(bus_rdata, '0, "R8 pend in reset");
    chk({{(N-1){1'b0}}, irq}, '0, "R8 irq in reset");
    bus_rd = 0;
    @(negedge clk);
    arst_n = 1;
    repeat (4) cyc('0, 0, 0, A_PND, '0, "R8 idle");
    cyc('0, 1, 0, A_PND, '0, "R8 pend after reset");
    cyc('0, 1, 0, A_MSK, '0, "R8 mask after reset");

    // R6 mask arm/disarm
    cyc('0, 0, 1, A_ARM, 32'hA5A5_0F0F, "R6 arm");
    cyc('0, 1, 0, A_MSK, '0, "R6 mask after arm");
    cyc('0, 0, 1, A_ARM, '0, "R6 arm zeros");
    cyc('0, 1, 0, A_MSK, '0, "R6 zeros no effect");
    cyc('0, 0, 1, A_DIS, 32'h0000_0F00, "R6 disarm");
    cyc('0, 1, 0, A_MSK, '0, "R6 mask after disarm");
    cyc('0, 0, 1, A_DIS, '0, "R6 disarm zeros");
    cyc('0, 0, 1, A_ARM, 32'hFFFF_FFFF, "R6 arm all");
    cyc('0, 0, 1, A_DIS, 32'h5555_5555, "R6 disarm odd");
    cyc('0, 1, 0, A_MSK, '0, "R6 mask readback");
    cyc('0, 1, 0, 8'h30, '0, "R9 unmapped read");

    // R1 edges, with R5 read colliding with a rising edge
    set_all(3'd1);
    cyc('0, 1, 0, A_PND, '0, "R1 rise idle");
    cyc('1, 1, 0, A_PND, '0, "R5 rise during read");
    cyc('1, 1, 0, A_PND, '0, "R5 rise kept after read");
    cyc('1, 1, 0, A_PND, '0, "R1 no repeat on steady high");
    set_all(3'd0);
    cyc('0, 0, 0, A_PND, '0, "R1 fall");
    cyc('0, 1, 0, A_MSK, '0, "R9 mask read keeps pend");
    cyc('0, 0, 1, A_ARM, 32'h0000_00FF, "R9 arm keeps pend");
    cyc('0, 1, 0, A_PND, '0, "R1 fall seen");
    set_all(3'd2);
    cyc(32'h0000_FFFF, 0, 0, A_PND, '0, "R1 both up");
    cyc(32'hFFFF_0000, 1, 0, A_PND, '0, "R1 both swap");
    cyc(32'hFFFF_0000, 1, 0, A_PND, '0, "R1 both seen");

    // R2 levels
    set_all(3'd3);
    cyc('0, 1, 0, A_PND, '0, "R2 low read");
    cyc('0, 1, 0, A_PND, '0, "R2 low persists");
    cyc('1, 1, 0, A_PND, '0, "R2 low gone read");
    cyc('1, 1, 0, A_PND, '0, "R2 low cleared");
    set_all(3'd4);
    cyc('1, 1, 0, A_PND, '0, "R2 high read");
    cyc('0, 1, 0, A_PND, '0, "R2 high persists");
    cyc('0, 1, 0, A_PND, '0, "R2 high cleared");

    // R3 reserved codes
    for (int s = 5; s < 8; s++) begin
      set_all(3'(s));
      cyc('1, 0, 0, A_PND, '0, "R3 reserved hi");
      cyc('0, 0, 0, A_PND, '0, "R3 reserved lo");
      cyc('1, 1, 0, A_PND, '0, "R3 reserved read");
    end

    // R7 masked latch then unmask
    set_all(3'd1);
    cyc('0, 0, 1, A_DIS, '1, "R7 disarm all");
    cyc(32'h8000_0001, 0, 0, A_PND, '0, "R7 event while masked");
    cyc(32'h8000_0001, 0, 1, A_ARM, 32'h8000_0000, "R7 unmask one");
    cyc(32'h8000_0001, 1, 0, A_PND, '0, "R7 masked latched");

    // sweep: all eight codes across lines, pseudo-random pins
    for (int i = 0; i < N; i++) sel_b[i] = 3'(i % 8);
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 37 == 5)      cyc(lfsr, 0, 1, A_DIS, lfsr ^ 32'h3C3C_3C3C, "R1 R2 R3 sweep disarm");
      else if (k % 23 == 7) cyc(lfsr, 0, 1, A_ARM, ~lfsr, "R1 R2 R3 sweep arm");
      else if (k % 5 == 1)  cyc(lfsr, 1, 0, A_MSK, '0, "R9 sweep mask read");
      else                  cyc(lfsr, (k % 3 == 0), 0, A_PND, '0, "R1 R2 R3 R4 sweep");
    end
    cyc(lfsr, 1, 0, A_PND, '0, "R4 final read");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule